// File: doc/BRIEF.md
# NAND Flash Strobe Timing Sequencer

This block turns a single request into one bus cycle on an 8-bit NAND flash device. A request carries a read/write flag, a two-bit selector choosing data, command or address, and a byte to write. Four 8-bit timing fields decide how long each phase of the cycle lasts. The phases are setup before the strobe, the strobe itself, hold after the strobe, and, for writes only, a window at the start of the access during which the byte bus stays undriven.

The block drives active-low chip enable, read enable and write enable. It also drives the command-latch and address-latch enables and the drive enable of the shared byte bus. A ready/busy input can stretch the strobe phase. When the access finishes, the block returns a one-cycle done pulse and, for reads, the captured byte. Multi-byte commands and any number of address bytes are sent by issuing one request per byte.

The timing fields hold offset values: setup cycles minus 1, strobe cycles minus 2, and hold cycles minus 1. The high-Z field holds its cycle count directly. The fields must stay stable while an access is in flight.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset and whenever no access is in flight, ce_n, re_n and we_n are high, cle, ale, bus_oe and done are low, and idle is high.
- R2: A request sampled with req_valid high while idle starts an access on the next cycle. ce_n falls, and the strobe stays high for cfg_setup+1 cycles (1 to 256).
- R3: With rdy high, the strobe (re_n for reads, we_n for writes) stays low for cfg_wait+2 cycles (2 to 257).
- R4: If rdy is low when the strobe phase has run its programmed length, the strobe stays low. It rises on the first clock edge at which rdy is sampled high.
- R5: After the strobe rises, ce_n stays low for cfg_hold+1 cycles (1 to 256) and then rises.
- R6: For the whole access, req_kind 2'b01 drives cle high and ale low, and 2'b10 drives ale high and cle low. 2'b00 and 2'b11 are data cycles with both low.
- R7: A read access never lowers we_n and never raises bus_oe. A write access never lowers re_n.
- R8: On a write, bus_oe is low for the first cfg_hiz cycles of the access (cycle 0 is the first cycle with ce_n low). It is then high, with bus_out equal to the request byte, until ce_n rises.
- R9: done is high for exactly one cycle, the first cycle after ce_n rises. On a read, rdata then holds bus_in as sampled on the edge where re_n rose.
- R10: Requests presented while an access is in flight are ignored. They change neither the kind, the direction nor the length of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_kind | input | 2 | 00/11 data, 01 command, 10 address |
| req_wdata | input | DW | Byte to write |
| cfg_setup | input | TW | Setup cycles minus 1 |
| cfg_wait | input | TW | Strobe cycles minus 2 |
| cfg_hold | input | TW | Hold cycles minus 1 |
| cfg_hiz | input | TW | Write high-Z cycles from access start |
| rdy | input | 1 | Device ready (1) / busy (0) |
| bus_in | input | DW | Byte bus value seen at the pins |
| bus_out | output | DW | Byte driven onto the bus |
| bus_oe | output | 1 | Bus drive enable |
| ce_n | output | 1 | Chip enable, active low |
| re_n | output | 1 | Read enable, active low |
| we_n | output | 1 | Write enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| idle | output | 1 | High when a request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Byte captured on a read |

## Verification
The assertions check the cycle-invariant rules on every cycle:
- the two strobes are never low together;
- a strobe or latch enable is only active inside chip enable;
- bus drive never overlaps a read strobe;
- done lasts one cycle;
- every strobe lasts at least the programmed wait;
- every strobe ends only after ready was sampled high.

Exact phase lengths, the start cycle of bus drive, the captured read byte, the stretch length under busy and the rejection of requests during an access depend on the programmed values. Only the bench's directed scenarios can show these, by counting cycles at the pins against values computed from the requirements.

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq #(
  parameter int DW = 8,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_kind,
  input  logic [DW-1:0] req_wdata,
  input  logic [TW-1:0] cfg_setup,
  input  logic [TW-1:0] cfg_wait,
  input  logic [TW-1:0] cfg_hold,
  input  logic [TW-1:0] cfg_hiz,
  input  logic          rdy,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          ce_n,
  output logic          re_n,
  output logic          we_n,
  output logic          cle,
  output logic          ale,
  output logic          idle,
  output logic          done,
  output logic [DW-1:0] rdata
);
  localparam int CW = TW + 1;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [TW-1:0] elapsed;
  logic          wr_q;
  logic [1:0]    kind_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      elapsed <= '0;
      wr_q    <= 1'b0;
      kind_q  <= 2'b00;
      wdata_q <= '0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      if (st != S_IDLE && elapsed != {TW{1'b1}})
        elapsed <= elapsed + TW'(1);
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            st      <= S_SETUP;
            cnt     <= CW'(cfg_setup);
            elapsed <= '0;
            wr_q    <= req_write;
            kind_q  <= req_kind;
            wdata_q <= req_wdata;
          end
        end
        S_SETUP: begin
          if (cnt == '0) begin
            st  <= S_STROBE;
            cnt <= CW'(cfg_wait) + CW'(1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        S_STROBE: begin
          if (cnt != '0) begin
            cnt <= cnt - CW'(1);
          end else if (rdy) begin
            st  <= S_HOLD;
            cnt <= CW'(cfg_hold);
            if (!wr_q) rdata <= bus_in;
          end
        end
        default: begin
          if (cnt == '0) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
      endcase
    end
  end

  assign idle    = (st == S_IDLE);
  assign ce_n    = idle;
  assign re_n    = !(st == S_STROBE && !wr_q);
  assign we_n    = !(st == S_STROBE && wr_q);
  assign cle     = !idle && (kind_q == 2'b01);
  assign ale     = !idle && (kind_q == 2'b10);
  assign bus_oe  = !idle && wr_q && (elapsed >= cfg_hiz);
  assign bus_out = wdata_q;

endmodule

// File: rtl/nand_strobe_seq_chk.sv
module nand_strobe_seq_chk #(
  parameter int DW = 8,
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] cfg_wait,
  input logic          rdy,
  input logic          bus_oe,
  input logic          ce_n,
  input logic          re_n,
  input logic          we_n,
  input logic          cle,
  input logic          ale,
  input logic          done,
  input logic [DW-1:0] rdata
);
  logic        strb, strb_q;
  logic [15:0] slen;

  assign strb = !re_n || !we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strb_q <= 1'b0;
      slen   <= '0;
    end else begin
      strb_q <= strb;
      if (!strb) slen <= '0;
      else if (slen != 16'hFFFF) slen <= slen + 16'd1;
    end
  end

  AST_ENTRY_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_n) |-> (re_n && we_n)); // R2
  AST_STROBE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_q && !strb) |-> (32'(slen) >= 32'(cfg_wait) + 32'd2)); // R3
  AST_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_q && !strb) |-> $past(rdy)); // R4
  AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
    strb |-> !ce_n); // R5
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale)); // R6
  AST_LATCH_IN_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (cle || ale) |-> !ce_n); // R6
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!re_n && !we_n)); // R7
  AST_OE_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!ce_n && re_n)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AFTER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ce_n && $past(!ce_n))); // R9
  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && $past(ce_n)) |-> $stable(rdata)); // R9

endmodule

bind nand_strobe_seq nand_strobe_seq_chk #(.DW(DW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .rdy(rdy),
  .bus_oe(bus_oe), .ce_n(ce_n), .re_n(re_n), .we_n(we_n),
  .cle(cle), .ale(ale), .done(done), .rdata(rdata)
);

// File: tb/sim_nand_strobe_seq.sv
module sim_nand_strobe_seq;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, rdy = 1'b1;
  logic [1:0] req_kind = 2'b00;
  logic [7:0] req_wdata = '0, cfg_setup = '0, cfg_wait = '0, cfg_hold = '0, cfg_hiz = '0;
  logic [7:0] bus_in = '0, bus_out, rdata;
  logic       bus_oe, ce_n, re_n, we_n, cle, ale, idle, done;

  int checks = 0, errors = 0;
  bit finished = 0;

  int m_s, m_w, m_h, m_oe_bad, m_lat_bad, m_other, m_done_bad, m_first_oe;
  bit m_done_ok, m_done_clr;
  logic [7:0] m_rd, m_exp_rd;

  always #10 clk = ~clk;

  nand_strobe_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_kind(req_kind), .req_wdata(req_wdata), .cfg_setup(cfg_setup),
    .cfg_wait(cfg_wait), .cfg_hold(cfg_hold), .cfg_hiz(cfg_hiz), .rdy(rdy),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .ce_n(ce_n),
    .re_n(re_n), .we_n(we_n), .cle(cle), .ale(ale), .idle(idle),
    .done(done), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input bit wr, input logic [1:0] kind, input logic [7:0] wd,
                     input logic [7:0] s, input logic [7:0] w, input logic [7:0] h,
                     input logic [7:0] z, input int rel, input bit keep);
    int k = 0, ph = 0;
    bit st;
    m_s = 0; m_w = 0; m_h = 0; m_oe_bad = 0; m_lat_bad = 0; m_other = 0;
    m_done_bad = 0; m_first_oe = -1; m_done_ok = 0; m_done_clr = 0; m_exp_rd = 'x;
    @(negedge clk);
    cfg_setup = s; cfg_wait = w; cfg_hold = h; cfg_hiz = z;
    req_valid = 1; req_write = wr; req_kind = kind; req_wdata = wd;
    rdy = (rel > 0) ? 1'b0 : 1'b1;
    @(negedge clk);
    if (keep) begin
      req_write = !wr; req_kind = ~kind; req_wdata = ~wd;
    end else begin
      req_valid = 0;
    end
    for (int it = 0; it < 3000; it++) begin
      if (!ce_n) begin
        st = wr ? !we_n : !re_n;
        if (wr ? !re_n : !we_n) m_other++;
        if (ph == 0 && st) ph = 1;
        else if (ph == 1 && !st) ph = 2;
        if (ph == 0) m_s++; else if (ph == 1) m_w++; else m_h++;
        if (cle !== (kind == 2'b01) || ale !== (kind == 2'b10)) m_lat_bad++;
        if (bus_oe !== (wr && k >= int'(z))) m_oe_bad++;
        if (bus_oe && m_first_oe < 0) m_first_oe = k;
        if (bus_oe && bus_out !== wd) m_oe_bad++;
        if (done) m_done_bad++;
        if (ph == 1 && !wr) begin bus_in = 8'(k * 37 + 11); m_exp_rd = bus_in; end
        if (ph == 1 && rel > 0 && m_w == rel) rdy = 1;
        if (ph == 2 && keep) req_valid = 0;
        k++;
      end else begin
        m_done_ok = (done === 1'b1) && (k > 0);
        m_rd = rdata;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    m_done_clr = (done === 1'b0) && (ce_n === 1'b1);
    bus_in = 8'h00;
    rdy = 1;
  endtask

  task automatic t_reset;
    chk(ce_n === 1 && re_n === 1 && we_n === 1, "R1 strobes idle", {ce_n, re_n, we_n}, 7);
    chk(cle === 0 && ale === 0 && bus_oe === 0, "R1 latch/oe idle", {cle, ale, bus_oe}, 0);
    chk(done === 0 && idle === 1, "R1 done/idle", {done, idle}, 1);
  endtask

  task automatic t_read_basic;
    run(0, 2'b00, 8'h00, 8'd2, 8'd3, 8'd1, 8'd0, 0, 0);
    chk(m_s == 3, "R2 read setup", m_s, 3);
    chk(m_w == 5, "R3 read strobe", m_w, 5);
    chk(m_h == 2, "R5 read hold", m_h, 2);
    chk(m_other == 0 && m_oe_bad == 0, "R7 read no we/oe", m_other + m_oe_bad, 0);
    chk(m_done_ok && m_done_clr && m_done_bad == 0, "R9 done pulse", m_done_ok, 1);
    chk(m_rd === m_exp_rd, "R9 read capture", m_rd, m_exp_rd);
    chk(m_lat_bad == 0, "R6 data kind latches", m_lat_bad, 0);
  endtask

  task automatic t_write_cmd;
    run(1, 2'b01, 8'h70, 8'd0, 8'd0, 8'd0, 8'd2, 0, 0);
    chk(m_s == 1 && m_w == 2 && m_h == 1, "R3 minimum phases", m_s * 100 + m_w * 10 + m_h, 121);
    chk(m_lat_bad == 0, "R6 command cle", m_lat_bad, 0);
    chk(m_oe_bad == 0 && m_first_oe == 2, "R8 write hiz 2", m_first_oe, 2);
    chk(m_other == 0, "R7 write no re", m_other, 0);
    chk(m_done_ok && m_done_clr, "R9 write done", m_done_ok, 1);
  endtask

  task automatic t_write_addr;
    run(1, 2'b10, 8'h3C, 8'd4, 8'd1, 8'd3, 8'd0, 0, 0);
    chk(m_lat_bad == 0, "R6 address ale", m_lat_bad, 0);
    chk(m_oe_bad == 0 && m_first_oe == 0, "R8 hiz zero", m_first_oe, 0);
    chk(m_s == 5 && m_h == 4, "R5 hold 4", m_h, 4);
  endtask

  task automatic t_hiz_long;
    run(1, 2'b11, 8'hA1, 8'd1, 8'd1, 8'd1, 8'd200, 0, 0);
    chk(m_oe_bad == 0 && m_first_oe == -1, "R8 hiz beyond access", m_first_oe, -1);
    chk(m_lat_bad == 0, "R6 kind 11 is data", m_lat_bad, 0);
  endtask

  task automatic t_ready_ext;
    run(0, 2'b00, 8'h00, 8'd1, 8'd2, 8'd0, 8'd0, 9, 0);
    chk(m_w == 9, "R4 busy stretch", m_w, 9);
    chk(m_rd === m_exp_rd, "R4 capture after stretch", m_rd, m_exp_rd);
    chk(m_h == 1, "R5 hold after stretch", m_h, 1);
  endtask

  task automatic t_ignore;
    run(0, 2'b01, 8'h00, 8'd1, 8'd1, 8'd2, 8'd0, 0, 1);
    chk(m_s == 2 && m_w == 3 && m_h == 3, "R10 lengths unchanged", m_s * 100 + m_w * 10 + m_h, 233);
    chk(m_lat_bad == 0 && m_other == 0 && m_oe_bad == 0, "R10 kind/dir unchanged",
        m_lat_bad + m_other + m_oe_bad, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(ce_n === 1 && idle === 1, "R10 no extra access", ce_n, 1);
    end
  endtask

  task automatic t_max;
    run(1, 2'b00, 8'h5A, 8'd255, 8'd254, 8'd254, 8'd255, 0, 0);
    chk(m_s == 256, "R2 max setup", m_s, 256);
    chk(m_w == 256, "R3 max strobe", m_w, 256);
    chk(m_h == 255, "R5 max hold", m_h, 255);
    chk(m_oe_bad == 0 && m_first_oe == 255, "R8 max hiz", m_first_oe, 255);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read_basic();
    t_write_cmd();
    t_write_addr();
    t_hiz_long();
    t_ready_ext();
    t_ignore();
    t_max();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule